// File: doc/BRIEF.md
# Backup-Domain Clock Control Register

This block is one 32-bit memory-mapped control word that lives in an always-on reset domain. It holds the settings for the low-speed crystal oscillator: enable, bypass and a 2-bit drive strength. It also holds the real-time-clock source selection and the RTC clock enable. A software-controlled bit makes the register's own protected fields return to their reset values. The oscillators themselves are outside the block. The block sees their activity only as single-cycle tick strobes in its own clock domain, together with a raw oscillator-ready level that it synchronizes before software can read it.

A power-control block supplies a write-enable level. While that level is low, writes to the oscillator and RTC fields are dropped. Once the RTC source field is nonzero it can no longer be changed until a backup-domain reset, either from the domain reset pin or from the software reset bit. The block gates the selected tick onto a single RTC tick output. The candidate ticks are the low-speed crystal, the internal RC oscillator and the high-speed crystal divided by 128.

Top module: `bkdom_clkctl`

## Requirements
- R1: After `rst_n` is released the register reads 0x0000_0018: drive strength bits 4:3 are 11 and every other bit is 0.
- R2: A write updates only the byte lanes whose `wstrb` bit is 1. Lane 0 carries bits 7:0, lane 1 carries bits 15:8 and lane 2 carries bit 16. A write with no strobe set changes nothing.
- R3: Oscillator enable (bit 0), bypass (bit 2), drive (bits 4:3), RTC source (bits 9:8) and RTC enable (bit 15) change only on a write made while `bkp_wen` is 1. The reset-request bit 16 is writable whatever `bkp_wen` is.
- R4: RTC source encoding is 00 none, 01 low-speed crystal tick, 10 internal RC tick, 11 high-speed crystal tick divided by 128. With source 11 the output pulses on the 128th, 256th, and every further 128th input tick counted from the last backup-domain reset.
- R5: While the RTC source field is nonzero, writes to it are ignored, including writes of 00. The other fields in the same lane still update.
- R6: Bit 16 is set and cleared by software. While it is 1, or on the write that sets it, every protected field is held at its reset value and writes to those fields are ignored.
- R7: Reserved bits 31:17, 14:10 and 7:5 always read 0. Bit 1 is read-only and ignores writes.
- R8: Bit 1 reports `osc_ready` through a two-flop synchronizer. A change becomes visible to a read captured on the third rising edge after the input changes.
- R9: `rtc_tick` stays 0 whenever RTC enable is 0 or the source field is 00.
- R10: `rdata` is registered. It presents the word in the cycle after `rd_en`, and a read has no side effect. Accesses whose word address differs from `REG_OFS` (0x20 by default) read 0 and are not written.
- R11: The outputs `osc_en`, `osc_bypass`, `osc_drive`, `rtc_src`, `rtc_en` and `bkp_rst_req` always equal the register fields they mirror.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low backup-domain reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane write strobes |
| rdata | output | 32 | Registered read data |
| bkp_wen | input | 1 | Write permission for the protected fields |
| osc_ready | input | 1 | Asynchronous low-speed oscillator ready level |
| lxt_tick | input | 1 | Low-speed crystal tick strobe |
| irc_tick | input | 1 | Internal RC tick strobe |
| hxt_tick | input | 1 | High-speed crystal tick strobe |
| osc_en | output | 1 | Low-speed oscillator enable |
| osc_bypass | output | 1 | Low-speed oscillator bypass |
| osc_drive | output | 2 | Low-speed oscillator drive strength |
| rtc_en | output | 1 | RTC clock enable |
| rtc_src | output | 2 | RTC source selection |
| bkp_rst_req | output | 1 | Software backup-domain reset request |
| rtc_tick | output | 1 | Gated, selected RTC tick |

## Verification
The bench attacks the write-once source field in two ways. It writes a new nonzero code and it writes 00. A design that compares against the write data instead of the stored field would let the source drift or fall back to "none". The software reset bit is exercised while the field writes are locked out, and again together with a field write. A design that treats bit 16 as protected, or that clears the fields a cycle late, returns stale values on the next read. The divide-by-128 path is counted over 256 input ticks, which exposes an off-by-one terminal count. Reads are timed around the synchronizer so that a missing or extra stage shows up as the stable bit appearing one read too early or too late.

// File: rtl/bkc_pkg.sv
// Package: shared field layout, reset values and types for the backup-domain
// clock control register. Assumes a 32-bit register word.
package bkc_pkg;

    localparam int REG_W = 32;

    // Bit positions that software and the readback path depend on.
    localparam int POS_OSC_EN  = 0;
    localparam int POS_STABLE  = 1;
    localparam int POS_BYPASS  = 2;
    localparam int POS_DRV_LO  = 3;
    localparam int POS_SRC_LO  = 8;
    localparam int POS_RTC_EN  = 15;
    localparam int POS_BKRST   = 16;

    // Bits that always read as zero.
    localparam logic [REG_W-1:0] RSVD_MASK = 32'hFFFE_7CE0;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_LXT  = 2'b01,
        SRC_IRC  = 2'b10,
        SRC_HXT  = 2'b11
    } rtc_src_e;

    typedef struct packed {
        logic       bkrst;
        logic       rtc_en;
        rtc_src_e   src;
        logic [1:0] drive;
        logic       bypass;
        logic       osc_en;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        bkrst:  1'b0,
        rtc_en: 1'b0,
        src:    SRC_NONE,
        drive:  2'b11,
        bypass: 1'b0,
        osc_en: 1'b0
    };

endpackage

// File: rtl/bkc_sync.sv
// Multi-flop level synchronizer for an asynchronous input.
// Assumes the input is a slow level; reset value is 0.
module bkc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bkc_prescale.sv
// Tick prescaler: emits one output strobe every 2**LOG2 input strobes.
// Assumes input strobes are single-cycle; clr restarts the count.
module bkc_prescale #(
    parameter int LOG2 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic tick_out
);
    logic [LOG2-1:0] cnt_q;

    // Count input strobes, wrapping at the terminal value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_out = tick_in && (cnt_q == {LOG2{1'b1}}) && !clr;
endmodule

// File: rtl/bkc_fields.sv
// Protected field storage: lane-gated writes, write-permission gating,
// write-once source selection and self reset via the software reset bit.
// Assumes wr_hit is already qualified by address decode.
module bkc_fields
    import bkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [2:0] lane,
    input  logic       bkp_wen,
    input  logic       wd_osc_en,
    input  logic       wd_bypass,
    input  logic [1:0] wd_drive,
    input  logic [1:0] wd_src,
    input  logic       wd_rtc_en,
    input  logic       wd_bkrst,
    output ctl_t       ctl
);
    ctl_t ctl_q;
    logic bkrst_d;
    logic hold_rst;
    logic wr_lo;
    logic wr_hi;

    // Next value of the software reset bit (not write protected).
    assign bkrst_d  = (wr_hit && lane[2]) ? wd_bkrst : ctl_q.bkrst;
    // Protected fields stay at reset while the bit is, or is becoming, 1.
    assign hold_rst = ctl_q.bkrst || bkrst_d;
    assign wr_lo    = wr_hit && lane[0] && bkp_wen;
    assign wr_hi    = wr_hit && lane[1] && bkp_wen;

    // Update the control fields on permitted writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q.bkrst <= bkrst_d;
            if (hold_rst) begin
                ctl_q.rtc_en <= CTL_RST.rtc_en;
                ctl_q.src    <= CTL_RST.src;
                ctl_q.drive  <= CTL_RST.drive;
                ctl_q.bypass <= CTL_RST.bypass;
                ctl_q.osc_en <= CTL_RST.osc_en;
            end else begin
                if (wr_lo) begin
                    ctl_q.osc_en <= wd_osc_en;
                    ctl_q.bypass <= wd_bypass;
                    ctl_q.drive  <= wd_drive;
                end
                if (wr_hi) begin
                    ctl_q.rtc_en <= wd_rtc_en;
                    if (ctl_q.src == SRC_NONE) begin
                        ctl_q.src <= rtc_src_e'(wd_src);
                    end
                end
            end
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/bkc_clksel.sv
// RTC tick selector: routes one of three tick strobes by source code and
// gates the result with the RTC enable. Purely combinational.
module bkc_clksel
    import bkc_pkg::*;
(
    input  rtc_src_e src,
    input  logic     enable,
    input  logic     tick_lxt,
    input  logic     tick_irc,
    input  logic     tick_hxt_div,
    output logic     tick_out
);
    logic picked;

    // Pick the strobe named by the source code.
    always_comb begin
        case (src)
            SRC_LXT: picked = tick_lxt;
            SRC_IRC: picked = tick_irc;
            SRC_HXT: picked = tick_hxt_div;
            default: picked = 1'b0;
        endcase
    end

    assign tick_out = enable && picked;
endmodule

// File: rtl/bkdom_clkctl.sv
// Backup-domain clock control register top: address decode, readback,
// oscillator-ready synchronizer, prescaler and RTC tick selection.
// Assumes all tick inputs are single-cycle strobes in the clk domain.
module bkdom_clkctl
    import bkc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFS     = 8'h20,
    parameter int                SYNC_STAGES = 2,
    parameter int                DIV_LOG2    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    output logic [31:0]       rdata,
    input  logic              bkp_wen,
    input  logic              osc_ready,
    input  logic              lxt_tick,
    input  logic              irc_tick,
    input  logic              hxt_tick,
    output logic              osc_en,
    output logic              osc_bypass,
    output logic [1:0]        osc_drive,
    output logic              rtc_en,
    output logic [1:0]        rtc_src,
    output logic              bkp_rst_req,
    output logic              rtc_tick
);
    localparam int WA_HI = ADDR_W - 1;

    ctl_t        ctl;
    logic        hit;
    logic        stable;
    logic        hxt_div;
    logic [31:0] word;
    logic        unused_bits;

    // Word-aligned address match.
    assign hit = (addr[WA_HI:2] == REG_OFS[WA_HI:2]);

    // Bits of the access that carry no meaning here.
    assign unused_bits = ^{addr[1:0], wstrb[3], wdata[31:17], wdata[14:10],
                           wdata[7:5], wdata[1]};

    bkc_fields u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_en && hit),
        .lane      (wstrb[2:0]),
        .bkp_wen   (bkp_wen),
        .wd_osc_en (wdata[POS_OSC_EN]),
        .wd_bypass (wdata[POS_BYPASS]),
        .wd_drive  (wdata[POS_DRV_LO+1:POS_DRV_LO]),
        .wd_src    (wdata[POS_SRC_LO+1:POS_SRC_LO]),
        .wd_rtc_en (wdata[POS_RTC_EN]),
        .wd_bkrst  (wdata[POS_BKRST]),
        .ctl       (ctl)
    );

    bkc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (osc_ready),
        .dout  (stable)
    );

    bkc_prescale #(.LOG2(DIV_LOG2)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.bkrst),
        .tick_in  (hxt_tick),
        .tick_out (hxt_div)
    );

    bkc_clksel u_sel (
        .src          (ctl.src),
        .enable       (ctl.rtc_en),
        .tick_lxt     (lxt_tick),
        .tick_irc     (irc_tick),
        .tick_hxt_div (hxt_div),
        .tick_out     (rtc_tick)
    );

    // Assemble the readback word; reserved bits stay zero.
    always_comb begin
        word                              = '0;
        word[POS_OSC_EN]                  = ctl.osc_en;
        word[POS_STABLE]                  = stable;
        word[POS_BYPASS]                  = ctl.bypass;
        word[POS_DRV_LO+1:POS_DRV_LO]     = ctl.drive;
        word[POS_SRC_LO+1:POS_SRC_LO]     = ctl.src;
        word[POS_RTC_EN]                  = ctl.rtc_en;
        word[POS_BKRST]                   = ctl.bkrst;
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= hit ? word : '0;
        end
    end

    assign osc_en      = ctl.osc_en;
    assign osc_bypass  = ctl.bypass;
    assign osc_drive   = ctl.drive;
    assign rtc_en      = ctl.rtc_en;
    assign rtc_src     = ctl.src;
    assign bkp_rst_req = ctl.bkrst;
endmodule

// File: rtl/bkdom_clkctl_chk.sv
// Assertion checker for bkdom_clkctl, attached with bind below.
module bkdom_clkctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bkp_wen,
    input logic [31:0] rdata,
    input logic        osc_en,
    input logic        osc_bypass,
    input logic [1:0]  osc_drive,
    input logic        rtc_en,
    input logic [1:0]  rtc_src,
    input logic        bkp_rst_req,
    input logic        rtc_tick
);
    // R5: a nonzero source only changes through a backup-domain reset.
    a_r5_src_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_src != 2'b00) |=> (rtc_src == $past(rtc_src)) || bkp_rst_req);

    // R3: without write permission the protected fields hold.
    a_r3_protect: assert property (@(posedge clk) disable iff (!rst_n)
        !bkp_wen |=> ($stable(osc_en) && $stable(osc_bypass) && $stable(osc_drive)
                      && $stable(rtc_en) && $stable(rtc_src)) || bkp_rst_req);

    // R6: while the reset request is set, fields sit at reset values.
    a_r6_hold_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_rst_req |-> (rtc_src == 2'b00) && !rtc_en && !osc_en
                        && !osc_bypass && (osc_drive == 2'b11));

    // R9: no tick without enable and a source.
    a_r9_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_en || (rtc_src == 2'b00)) |-> !rtc_tick);

    // R7: reserved bits never read as one.
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & 32'hFFFE_7CE0) == 32'h0);
endmodule

bind bkdom_clkctl bkdom_clkctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bkp_wen     (bkp_wen),
    .rdata       (rdata),
    .osc_en      (osc_en),
    .osc_bypass  (osc_bypass),
    .osc_drive   (osc_drive),
    .rtc_en      (rtc_en),
    .rtc_src     (rtc_src),
    .bkp_rst_req (bkp_rst_req),
    .rtc_tick    (rtc_tick)
);

// File: tb/bkdom_clkctl_tb.sv
module bkdom_clkctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h20;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [31:0] rdata;
    logic        bkp_wen = 1'b0;
    logic        osc_ready = 1'b0;
    logic        lxt_tick = 1'b0;
    logic        irc_tick = 1'b0;
    logic        hxt_tick = 1'b0;
    logic        osc_en, osc_bypass, rtc_en, bkp_rst_req, rtc_tick;
    logic [1:0]  osc_drive, rtc_src;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bkdom_clkctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .bkp_wen(bkp_wen),
        .osc_ready(osc_ready), .lxt_tick(lxt_tick), .irc_tick(irc_tick),
        .hxt_tick(hxt_tick), .osc_en(osc_en), .osc_bypass(osc_bypass),
        .osc_drive(osc_drive), .rtc_en(rtc_en), .rtc_src(rtc_src),
        .bkp_rst_req(bkp_rst_req), .rtc_tick(rtc_tick)
    );

    // {wdata, wstrb, bkp_wen, expected readback}
    localparam int NV = 13;
    localparam logic [68:0] VEC [NV] = '{
        {32'h0000_0001, 4'h1, 1'b0, 32'h0000_0018},
        {32'h0000_0005, 4'h1, 1'b1, 32'h0000_0005},
        {32'h0000_001F, 4'h1, 1'b1, 32'h0000_001D},
        {32'hFFFF_FFFF, 4'h0, 1'b1, 32'h0000_001D},
        {32'h0000_8100, 4'h2, 1'b1, 32'h0000_811D},
        {32'h0000_0200, 4'h2, 1'b1, 32'h0000_011D},
        {32'h0000_0000, 4'h2, 1'b1, 32'h0000_011D},
        {32'hFFFE_E0E0, 4'hF, 1'b1, 32'h0000_8100},
        {32'h0001_0000, 4'h4, 1'b0, 32'h0001_0018},
        {32'h0000_8205, 4'h3, 1'b1, 32'h0001_0018},
        {32'h0000_0000, 4'h4, 1'b0, 32'h0000_0018},
        {32'h0000_8200, 4'h2, 1'b1, 32'h0000_8218},
        {32'h0000_0300, 4'h2, 1'b1, 32'h0000_0218}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R3 write without permission";
            1, 2:    return "R2 R7 lane0 write, bit1 read-only";
            3:       return "R2 no strobes";
            4:       return "R2 lane1 source select";
            5, 6:    return "R5 source write-once";
            7:       return "R7 reserved bits ignored";
            8:       return "R6 reset bit set";
            9:       return "R6 writes ignored while reset set";
            10:      return "R6 reset bit cleared";
            11:      return "R5 source writable after reset";
            default: return "R5 source locked again";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] s, input logic w);
        @(negedge clk);
        addr = a; wdata = d; wstrb = s; bkp_wen = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bkp_wen = 1'b0; wstrb = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic soft_reset();
        bus_write(8'h20, 32'h0001_0000, 4'h4, 1'b0);
        bus_write(8'h20, 32'h0000_0000, 4'h4, 1'b0);
    endtask

    logic [31:0] rd;
    logic [31:0] outs;
    int          nt;
    int          first;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h20, rd);
        check("R1 reset value", rd, 32'h0000_0018);
        check("R11 outputs after reset",
              {osc_en, osc_bypass, osc_drive, rtc_en, rtc_src, bkp_rst_req},
              {1'b0, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0});

        // R10 other address: not written, reads zero
        bus_write(8'h24, 32'hFFFF_FFFF, 4'hF, 1'b1);
        bus_read(8'h20, rd);
        check("R10 foreign write ignored", rd, 32'h0000_0018);
        bus_read(8'h24, rd);
        check("R10 foreign read zero", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_write(8'h20, VEC[i][68:37], VEC[i][36:33], VEC[i][32]);
            bus_read(8'h20, rd);
            check(vec_tag(i), rd, VEC[i][31:0]);
            outs = '0;
            outs[0] = osc_en; outs[2] = osc_bypass; outs[4:3] = osc_drive;
            outs[9:8] = rtc_src; outs[15] = rtc_en; outs[16] = bkp_rst_req;
            check("R11 field outputs", outs, VEC[i][31:0]);
        end

        // R8 synchronizer latency
        @(negedge clk);
        osc_ready = 1'b1;
        bus_read(8'h20, rd);
        check("R8 stable not yet visible", rd, 32'h0000_0218);
        bus_read(8'h20, rd);
        check("R8 stable visible", rd, 32'h0000_021A);
        bus_read(8'h20, rd);
        check("R10 read has no side effect", rd, 32'h0000_021A);
        osc_ready = 1'b0;
        repeat (3) @(negedge clk);

        // R9 enable low blocks ticks (source is 10)
        @(negedge clk);
        irc_tick = 1'b1; #1;
        check("R9 tick gated by enable", {31'b0, rtc_tick}, 32'd0);
        irc_tick = 1'b0;

        // R4 internal RC routed, crystal ignored
        bus_write(8'h20, 32'h0000_8200, 4'h2, 1'b1);
        @(negedge clk);
        irc_tick = 1'b1; #1;
        check("R4 source 10 routes RC tick", {31'b0, rtc_tick}, 32'd1);
        irc_tick = 1'b0; lxt_tick = 1'b1; #1;
        check("R4 source 10 ignores crystal", {31'b0, rtc_tick}, 32'd0);
        lxt_tick = 1'b0;

        // R4 divide by 128
        soft_reset();
        bus_write(8'h20, 32'h0000_8300, 4'h2, 1'b1);
        nt = 0; first = -1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            hxt_tick = 1'b1; #1;
            if (rtc_tick) begin
                nt++;
                if (first < 0) first = i;
            end
        end
        @(negedge clk);
        hxt_tick = 1'b0;
        check("R4 divided tick count", nt, 32'd2);
        check("R4 first divided tick index", first, 32'd127);

        // R4 low-speed crystal, R9 enable off
        soft_reset();
        bus_write(8'h20, 32'h0000_0100, 4'h2, 1'b1);
        @(negedge clk);
        lxt_tick = 1'b1; #1;
        check("R9 source 01 with enable low", {31'b0, rtc_tick}, 32'd0);
        lxt_tick = 1'b0;
        bus_write(8'h20, 32'h0000_8000, 4'h2, 1'b1);
        @(negedge clk);
        lxt_tick = 1'b1; #1;
        check("R4 source 01 routes crystal", {31'b0, rtc_tick}, 32'd1);
        lxt_tick = 1'b0;

        // R9 source 00 with enable high
        soft_reset();
        bus_write(8'h20, 32'h0000_8000, 4'h2, 1'b1);
        @(negedge clk);
        lxt_tick = 1'b1; irc_tick = 1'b1; hxt_tick = 1'b1; #1;
        check("R9 no source no tick", {31'b0, rtc_tick}, 32'd0);
        lxt_tick = 1'b0; irc_tick = 1'b0; hxt_tick = 1'b0;

        // R6 reset bit set together with a field write
        bus_write(8'h20, 32'h0001_0105, 4'h7, 1'b1);
        bus_read(8'h20, rd);
        check("R6 set with field write", rd, 32'h0001_0018);
        bus_write(8'h20, 32'h0, 4'h4, 1'b0);

        // R1 domain reset mid-run
        bus_write(8'h20, 32'h0000_8105, 4'h3, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(8'h20, rd);
        check("R1 value after domain reset", rd, 32'h0000_0018);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule